// File: doc/BRIEF.md
# Sleep-State Wake Event Controller

This block watches the wake sources of a system while it sits in a sleep state (S3, S4 or S5) and decides when to ask for a return to S0. The sources are four active-low PCI Express wake pins, a group of internal power-management event requests that are merged into one primary event, and a request raised by the power controller itself. Every source leaves a sticky status bit behind. A request that arrives while the system runs in S0 only records status. A request that arrives during sleep, or status left uncleared from before sleep entry, produces a single-cycle wake pulse. The status bits that were present at that moment are copied into a wake-cause record.

Gating depends on the sleep state. The PCI Express pins are stopped by one disable bit. The primary event needs its enable bit, and a second bit keeps it from waking the system out of S5 only. The controller-initiated request cannot be masked. After a global or go-to-S5 reset, wake is held off until the system next goes from S0 into a sleep state. The block also latches a power-failure flag when power loss is seen in S0. Software reaches the control bits, the status, the flag and the cause record through a small synchronous register port.

Top module: `wake_event_ctrl`

## Requirements
- R1: A low level on any `pcie_wake_n` pin passes through a two-stage synchronizer and sets status bit 0 (register 1). That status produces a wake pulse in sleep only when control bit 0 (PCI Express wake disable, register 0) is 0.
- R2: Any bit of `pme_req` sets status bit 1 (register 1). That status produces a wake pulse in sleep only when control bit 1 (primary event enable, register 0) is 1.
- R3: When control bit 2 (register 0) is 1, the primary event cannot wake the system while `slp_state` is S5 (encoding 3). In S3 (1) and S4 (2) the bit has no effect.
- R4: Primary event status set in S0 (encoding 0) and not cleared produces a wake pulse after the system enters a sleep state.
- R5: `ctl_wake_req` sets status bit 2 (register 1) in every state and always produces a wake pulse in sleep, whatever the control bits hold.
- R6: `wake_req` is high for exactly one cycle. It is never issued while `slp_state` is S0, and it is issued at most once between two visits to S0.
- R7: `power_lost` sets status bit 3 (register 1, also driven on `pwr_fail_flag`) only while `slp_state` is S0. It is ignored in sleep states.
- R8: After a `global_rst_evt` pulse, no wake pulse is issued until `slp_state` next moves from S0 to a sleep state. Status is still recorded meanwhile.
- R9: Status (register 1) and cause (register 2) bits are write-one-to-clear. A written 0 leaves a bit unchanged.
- R10: At each wake pulse, status bits 2:0 are ORed into the cause record (register 2, bits 2:0, also on `wake_cause`). The record holds them until software clears them.
- R11: After reset, every register reads 0 and `wake_req`, `wake_cause` and `pwr_fail_flag` are 0.
- R12: Register 0 keeps bits 2:0 of the written data and reads 0 in its upper bits. `reg_rdata` shows the register selected by `reg_addr` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pcie_wake_n | input | 4 | Active-low PCI Express wake pins, asynchronous |
| pme_req | input | 4 | Internal power-management event requests |
| ctl_wake_req | input | 1 | Controller-initiated wake request |
| slp_state | input | 2 | Current state: 0=S0, 1=S3, 2=S4, 3=S5 |
| power_lost | input | 1 | Power-loss indication |
| global_rst_evt | input | 1 | One-cycle pulse marking a global or go-to-S5 reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 cause |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| wake_req | output | 1 | One-cycle wake request pulse |
| wake_cause | output | 3 | Latched wake-cause record |
| pwr_fail_flag | output | 1 | Power-failure flag |

## Verification
The hardest case to reach is the wake caused by stale status, where nothing new happens in sleep. Status that was left set in S0 must fire on sleep entry. Status that was set while wake was suppressed after a global reset must stay quiet until a real S0-to-sleep transition. The bench gets there with directed sequences: it raises a source in S0, or next to a `global_rst_evt` pulse, and only later moves `slp_state`. Around those sequences sits a sweep over every control-bit combination, every sleep state and every source, each scored against an expectation computed from the gating rules.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    SLP_S0 = 2'd0,
    SLP_S3 = 2'd1,
    SLP_S4 = 2'd2,
    SLP_S5 = 2'd3
  } slp_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_STS   = 2'd1;
  localparam logic [1:0] ADDR_CAUSE = 2'd2;

  localparam int CTL_W         = 3;
  localparam int CTL_PCIE_DIS  = 0;
  localparam int CTL_PME_EN    = 1;
  localparam int CTL_PME_S5DIS = 2;

  localparam int STS_W    = 4;
  localparam int CAUSE_W  = 3;
  localparam int STS_PCIE = 0;
  localparam int STS_PME  = 1;
  localparam int STS_CTL  = 2;
  localparam int STS_PWR  = 3;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int   W      = 4,
  parameter int   STAGES = 2,
  parameter logic RST_V  = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= {W{RST_V}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wake_regs.sv
module wake_regs
  import wake_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [1:0]         addr,
  input  logic [DW-1:0]      wdata,
  input  logic [STS_W-1:0]   sts_set,
  input  logic               cause_load,
  input  logic [CAUSE_W-1:0] cause_val,
  output logic [CTL_W-1:0]   ctrl_q,
  output logic [STS_W-1:0]   sts_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [DW-1:0]      rdata
);
  logic wr_ctrl, wr_sts, wr_cause;
  assign wr_ctrl  = we && (addr == ADDR_CTRL);
  assign wr_sts   = we && (addr == ADDR_STS);
  assign wr_cause = we && (addr == ADDR_CAUSE);

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata[CTL_W-1:0];
  end

  // sticky status: a new event wins over a simultaneous clear
  for (genvar i = 0; i < STS_W; i++) begin : g_sts
    logic clr;
    assign clr = wr_sts && wdata[i];
    always_ff @(posedge clk) begin
      if (rst) sts_q[i] <= 1'b0;
      else     sts_q[i] <= sts_set[i] | (sts_q[i] & ~clr);
    end
  end

  for (genvar j = 0; j < CAUSE_W; j++) begin : g_cause
    logic clr;
    assign clr = wr_cause && wdata[j];
    always_ff @(posedge clk) begin
      if (rst) cause_q[j] <= 1'b0;
      else     cause_q[j] <= (cause_load & cause_val[j]) | (cause_q[j] & ~clr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      unique case (addr)
        ADDR_CTRL:  rdata <= DW'(ctrl_q);
        ADDR_STS:   rdata <= DW'(sts_q);
        ADDR_CAUSE: rdata <= DW'(cause_q);
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wake_arbiter.sv
module wake_arbiter
  import wake_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         slp_state,
  input  logic [CTL_W-1:0]   ctrl,
  input  logic [CAUSE_W-1:0] sts,
  input  logic               global_rst_evt,
  output logic               wake_req,
  output logic               cause_load,
  output logic [CAUSE_W-1:0] cause_val
);
  slp_e st;
  logic asleep, prev_s0, entry, suppress, sent, fire;
  logic [CAUSE_W-1:0] hit;

  assign st     = slp_e'(slp_state);
  assign asleep = (st != SLP_S0);
  assign entry  = asleep && prev_s0;

  assign hit[STS_PCIE] = sts[STS_PCIE] & ~ctrl[CTL_PCIE_DIS];
  assign hit[STS_PME]  = sts[STS_PME] & ctrl[CTL_PME_EN]
                         & ~(ctrl[CTL_PME_S5DIS] && (st == SLP_S5));
  assign hit[STS_CTL]  = sts[STS_CTL];

  assign fire = asleep && !suppress && !sent && (|hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_req <= 1'b0;
      sent     <= 1'b0;
      suppress <= 1'b0;
      prev_s0  <= 1'b1;
    end else begin
      wake_req <= fire;
      prev_s0  <= !asleep;
      sent     <= asleep ? (sent | fire) : 1'b0;
      if (global_rst_evt) suppress <= 1'b1;
      else if (entry)     suppress <= 1'b0;
    end
  end

  assign cause_load = fire;
  assign cause_val  = sts;
endmodule

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl
  import wake_pkg::*;
#(
  parameter int NUM_PCIE    = 4,
  parameter int NUM_PME     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PCIE-1:0] pcie_wake_n,
  input  logic [NUM_PME-1:0]  pme_req,
  input  logic                ctl_wake_req,
  input  logic [1:0]          slp_state,
  input  logic                power_lost,
  input  logic                global_rst_evt,
  input  logic                reg_we,
  input  logic [1:0]          reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  output logic                wake_req,
  output logic [CAUSE_W-1:0]  wake_cause,
  output logic                pwr_fail_flag
);
  logic [NUM_PCIE-1:0] pin_sync;
  logic [STS_W-1:0]    sts_set, sts_q;
  logic [CTL_W-1:0]    ctrl_q;
  logic                cause_load;
  logic [CAUSE_W-1:0]  cause_val;

  wake_sync #(.W(NUM_PCIE), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(pcie_wake_n), .q(pin_sync)
  );

  assign sts_set[STS_PCIE] = |(~pin_sync);
  assign sts_set[STS_PME]  = |pme_req;
  assign sts_set[STS_CTL]  = ctl_wake_req;
  assign sts_set[STS_PWR]  = power_lost && (slp_state == SLP_S0);

  wake_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .sts_set(sts_set), .cause_load(cause_load), .cause_val(cause_val),
    .ctrl_q(ctrl_q), .sts_q(sts_q), .cause_q(wake_cause), .rdata(reg_rdata)
  );

  wake_arbiter u_arb (
    .clk(clk), .rst(rst), .slp_state(slp_state), .ctrl(ctrl_q),
    .sts(sts_q[CAUSE_W-1:0]), .global_rst_evt(global_rst_evt),
    .wake_req(wake_req), .cause_load(cause_load), .cause_val(cause_val)
  );

  assign pwr_fail_flag = sts_q[STS_PWR];
endmodule

// File: rtl/wake_ctrl_chk.sv
module wake_ctrl_chk
  import wake_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [1:0]         slp_state,
  input logic               power_lost,
  input logic               ctl_wake_req,
  input logic               global_rst_evt,
  input logic               wake_req,
  input logic [CAUSE_W-1:0] wake_cause,
  input logic               pwr_fail_flag,
  input logic [STS_W-1:0]   sts_q
);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wake_req |=> !wake_req);

  a_r6_not_from_s0: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(slp_state) != SLP_S0);

  a_r5_ctl_status: assert property (@(posedge clk) disable iff (rst)
    ctl_wake_req |=> sts_q[STS_CTL]);

  a_r7_pwr_flag: assert property (@(posedge clk) disable iff (rst)
    (power_lost && slp_state == SLP_S0) |=> pwr_fail_flag);

  a_r10_cause_present: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> wake_cause != '0);

  a_r8_suppressed: assert property (@(posedge clk) disable iff (rst)
    global_rst_evt |=> ##1 !wake_req);
endmodule

bind wake_event_ctrl wake_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .slp_state(slp_state), .power_lost(power_lost),
  .ctl_wake_req(ctl_wake_req), .global_rst_evt(global_rst_evt),
  .wake_req(wake_req), .wake_cause(wake_cause),
  .pwr_fail_flag(pwr_fail_flag), .sts_q(sts_q)
);

// File: tb/sim_wake_event_ctrl.sv
module sim_wake_event_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pcie_wake_n = 4'hF;
  logic [3:0] pme_req = '0;
  logic       ctl_wake_req = 1'b0;
  logic [1:0] slp_state = 2'd0;
  logic       power_lost = 1'b0;
  logic       global_rst_evt = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       wake_req;
  logic [2:0] wake_cause;
  logic       pwr_fail_flag;

  int checks = 0;
  int failures = 0;
  int pcnt = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  wake_event_ctrl u0 (.*);

  always @(negedge clk) if (wake_req) pcnt++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; pcie_wake_n = 4'hF; pme_req = '0; ctl_wake_req = 1'b0;
    slp_state = 2'd0; power_lost = 1'b0; global_rst_evt = 1'b0; reg_we = 1'b0;
    cyc(2);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cyc(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    cyc(1);
    d = reg_rdata;
  endtask

  // src 0: PCI Express pin, 1: primary event, 2: controller request
  task automatic trigger(input int src, input int lane);
    case (src)
      0: begin pcie_wake_n[lane] = 1'b0; cyc(3); pcie_wake_n = 4'hF; end
      1: begin pme_req[lane] = 1'b1; cyc(1); pme_req = '0; end
      default: begin ctl_wake_req = 1'b1; cyc(1); ctl_wake_req = 1'b0; end
    endcase
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int base;
    // R11: reset state
    do_reset();
    chk(wake_req == 1'b0, "R11 wake_req", wake_req, 0);
    chk(wake_cause == 3'd0, "R11 wake_cause", wake_cause, 0);
    chk(pwr_fail_flag == 1'b0, "R11 pwr_fail_flag", pwr_fail_flag, 0);
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), rv);
      chk(rv == 8'd0, "R11 register", rv, 0);
    end

    // R12: control readback keeps bits 2:0
    wr(2'd0, 8'hFF); rd(2'd0, rv);
    chk(rv == 8'h07, "R12 ctrl width", rv, 7);
    wr(2'd0, 8'h05); rd(2'd0, rv);
    chk(rv == 8'h05, "R12 ctrl readback", rv, 5);

    // R1 R2 R3 R5 sweep: state x control x source
    for (int s = 1; s < 4; s++) begin
      for (int c = 0; c < 8; c++) begin
        for (int src = 0; src < 3; src++) begin
          bit exp;
          do_reset();
          wr(2'd0, 8'(c));
          slp_state = 2'(s);
          cyc(2);
          base = pcnt;
          trigger(src, (s + c) % 4);
          cyc(8);
          if (src == 0)      exp = !c[0];
          else if (src == 1) exp = c[1] && !(c[2] && s == 3);
          else               exp = 1'b1;
          chk((pcnt - base) == int'(exp),
              src == 0 ? "R1 pcie gating" : (src == 1 ? "R2 R3 primary gating" : "R5 ctl wake"),
              pcnt - base, int'(exp));
          rd(2'd2, rv);
          chk(rv == (exp ? 8'(1 << src) : 8'd0), "R10 cause after sweep wake", rv,
              exp ? (1 << src) : 0);
          rd(2'd1, rv);
          chk(rv[src] == 1'b1, "R1 R2 R5 status set", rv[src], 1);
          slp_state = 2'd0;
          cyc(2);
        end
      end
    end

    // R4, R6: status from S0 wakes on entry; no wake in S0; one per sleep
    do_reset();
    wr(2'd0, 8'h02);
    base = pcnt;
    trigger(1, 2);
    cyc(5);
    chk(pcnt == base, "R6 no wake in S0", pcnt - base, 0);
    slp_state = 2'd1;
    cyc(5);
    chk(pcnt - base == 1, "R4 stale status wakes on entry", pcnt - base, 1);
    trigger(2, 0);
    cyc(5);
    chk(pcnt - base == 1, "R6 one pulse per sleep", pcnt - base, 1);
    slp_state = 2'd0; cyc(2);
    slp_state = 2'd2; cyc(5);
    chk(pcnt - base == 2, "R6 new sleep period wakes again", pcnt - base, 2);
    chk(wake_cause == 3'b110, "R10 cause accumulates", wake_cause, 6);

    // R9, R10: write-one-to-clear, zeros ignored
    wr(2'd2, 8'h00); cyc(2);
    chk(wake_cause == 3'b110, "R9 cause write zero ignored", wake_cause, 6);
    wr(2'd2, 8'h02); cyc(1);
    chk(wake_cause == 3'b100, "R9 cause w1c", wake_cause, 4);
    wr(2'd1, 8'h00); rd(2'd1, rv);
    chk(rv == 8'h06, "R9 status write zero ignored", rv, 6);
    wr(2'd1, 8'h06); rd(2'd1, rv);
    chk(rv == 8'h00, "R9 status w1c", rv, 0);

    // R7: power loss in S0 only
    do_reset();
    power_lost = 1'b1; cyc(1); power_lost = 1'b0; cyc(1);
    chk(pwr_fail_flag == 1'b1, "R7 flag set in S0", pwr_fail_flag, 1);
    rd(2'd1, rv);
    chk(rv == 8'h08, "R7 status bit3", rv, 8);
    wr(2'd1, 8'h08); cyc(1);
    chk(pwr_fail_flag == 1'b0, "R7 flag cleared", pwr_fail_flag, 0);
    slp_state = 2'd3; cyc(1);
    power_lost = 1'b1; cyc(2); power_lost = 1'b0; cyc(1);
    chk(pwr_fail_flag == 1'b0, "R7 ignored in sleep", pwr_fail_flag, 0);

    // R8: suppression after global reset until next real entry
    do_reset();
    slp_state = 2'd1; cyc(3);
    global_rst_evt = 1'b1; slp_state = 2'd3; cyc(1);
    global_rst_evt = 1'b0;
    base = pcnt;
    trigger(2, 0); cyc(6);
    chk(pcnt == base, "R8 suppressed", pcnt - base, 0);
    rd(2'd1, rv);
    chk(rv[2] == 1'b1, "R8 status still recorded", rv[2], 1);
    slp_state = 2'd0; cyc(3);
    chk(pcnt == base, "R8 no wake in S0", pcnt - base, 0);
    slp_state = 2'd3; cyc(5);
    chk(pcnt - base == 1, "R8 wake after new entry", pcnt - base, 1);

    summary();
    $finish;
  end
endmodule